// File: doc/BRIEF.md
# Shared Timer Prescaler with Synchronized Halt

This block supplies count-enable pulses to a group of synchronous timer/counters that share one prescaler. A free-running prescaler counter offers four divided taps (divide by 8, 64, 256 and 1024). Each timer has its own 3-bit clock select that picks no clock, every system clock cycle, one of the divided taps, or the rising or falling edges of that timer's own external clock pin. The output for each timer is a one-cycle enable pulse. The timer counters themselves sit outside this block.

An 8-bit control register, loaded through a simple write port, holds a prescaler-reset bit that clears itself and a synchronization-mode bit. With the mode bit set, the reset bits keep the value written to them. The shared prescaler then stays in reset, and every timer running from a divided tap stays frozen. Software can configure all timers during this hold. Writing the mode bit back to zero clears the reset bits, and all tapped timers restart from the same prescaler phase on the same cycle.

External pins are sampled by the system clock through a two-flop synchronizer and an edge-detect register. They never pass through the prescaler. A pin must hold each level for longer than one system clock period to be counted.

Top module: `tpre_shared_prescaler`

## Requirements
- R1: The control register resets to 0x00. Bits 6 to 2 always read 0, whatever value is written to them.
- R2: Control bit 0 is the shared-prescaler reset and bit 1 is the second prescaler-reset flag. A write sets each bit to the written value. While bit 7 (synchronization mode) is 0, both bits clear in the cycle after the write.
- R3: While bit 7 reads 1, bits 1 and 0 keep their written value until the next write.
- R4: A write with bit 7 = 0 and bits 1:0 = 0 clears bits 1:0 at that edge. Timers on divided taps then restart from the same prescaler phase, so a divide-by-64 pulse always coincides with a divide-by-8 pulse.
- R5: Clock select code 0 gives no enable pulses.
- R6: Clock select code 1 gives an enable on every cycle, even while the prescaler reset is held.
- R7: Codes 2, 3, 4 and 5 give one pulse every 8, 64, 256 and 1024 cycles. The first pulse comes in the Nth cycle after the prescaler reset bit reads 0.
- R8: While control bit 0 reads 1, codes 2 to 5 give no enable pulses.
- R9: Code 7 gives one pulse for each rising edge of the timer's pin, and code 6 gives one for each falling edge. The pulse appears two clock edges after the first edge that samples the new pin level.
- R10: External-pin pulses are not affected by the prescaler reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write value |
| csel | input | NUM_TIMERS*3 | Per-timer clock select, timer i at bits [3i+2:3i] |
| ext_pin | input | NUM_TIMERS | Per-timer external clock pins |
| ctrl_rd | output | 8 | Current control register value |
| cnt_en | output | NUM_TIMERS | Per-timer count-enable pulses |

## Verification
The bench goes after the release instant. A design that cleared the prescaler one cycle late, or let it run during the hold, would place the first divide-by-8 pulse in the wrong cycle, or split the divide-by-8 and divide-by-64 phases. It also writes a one-shot reset outside synchronization mode: a register that failed to self-clear would hold every tapped timer frozen. It also toggles external pins while the prescaler reset is held, and while timers sit on code 0. A design that gated the external path with the reset, or swapped the edge polarities, would lose pulses or place them a cycle off. Reserved control bits are written with ones to catch storage that should not exist.

// File: rtl/tpre_pkg.sv
package tpre_pkg;

  localparam int CTRL_W   = 8;
  localparam int CSEL_W   = 3;
  localparam int MODE_BIT = 7;
  localparam int ARST_BIT = 1;
  localparam int SRST_BIT = 0;
  localparam int NUM_TAPS = 4;

  typedef enum logic [CSEL_W-1:0] {
    CS_OFF      = 3'd0,
    CS_SYS      = 3'd1,
    CS_DIV8     = 3'd2,
    CS_DIV64    = 3'd3,
    CS_DIV256   = 3'd4,
    CS_DIV1024  = 3'd5,
    CS_EXT_FALL = 3'd6,
    CS_EXT_RISE = 3'd7
  } csel_e;

  // number of low prescaler bits that must all be one for tap k to fire
  function automatic int tap_lsbs(input int k);
    case (k)
      0:       return 3;
      1:       return 6;
      2:       return 8;
      default: return 10;
    endcase
  endfunction

  // width of the shared counter: enough bits for the slowest tap
  function automatic int psc_width();
    return tap_lsbs(NUM_TAPS - 1);
  endfunction

  // map one clock select code onto the available enable sources
  function automatic logic pick_enable(input logic [CSEL_W-1:0] sel,
                                       input logic [NUM_TAPS-1:0] taps,
                                       input logic rise,
                                       input logic fall);
    case (sel)
      CS_OFF:      return 1'b0;
      CS_SYS:      return 1'b1;
      CS_DIV8:     return taps[0];
      CS_DIV64:    return taps[1];
      CS_DIV256:   return taps[2];
      CS_DIV1024:  return taps[3];
      CS_EXT_FALL: return fall;
      default:     return rise;
    endcase
  endfunction

  // next value of a prescaler-reset flag
  function automatic logic next_rst_flag(input logic cur,
                                         input logic mode,
                                         input logic wr,
                                         input logic wbit);
    if (wr)        return wbit;
    else if (mode) return cur;
    else           return 1'b0;
  endfunction

endpackage

// File: rtl/tpre_ctrl_reg.sv
module tpre_ctrl_reg
  import tpre_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] ctrl_rd,
  output logic              sync_rst,
  output logic              aux_rst
);

  logic mode_q, srst_q, arst_q;
  logic mode_d, srst_d, arst_d;

  always_comb begin
    mode_d = wr_en ? wr_data[MODE_BIT] : mode_q;
    srst_d = next_rst_flag(srst_q, mode_q, wr_en, wr_data[SRST_BIT]);
    arst_d = next_rst_flag(arst_q, mode_q, wr_en, wr_data[ARST_BIT]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      srst_q <= 1'b0;
      arst_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      srst_q <= srst_d;
      arst_q <= arst_d;
    end
  end

  always_comb begin
    ctrl_rd           = '0;
    ctrl_rd[MODE_BIT] = mode_q;
    ctrl_rd[ARST_BIT] = arst_q;
    ctrl_rd[SRST_BIT] = srst_q;
  end

  assign sync_rst = srst_q;
  assign aux_rst  = arst_q;

endmodule

// File: rtl/tpre_psc_core.sv
module tpre_psc_core
  import tpre_pkg::*;
#(
  parameter int PSC_W = psc_width()
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hold,
  output logic [NUM_TAPS-1:0] tap_pulse
);

  logic [PSC_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (hold) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end

  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
    localparam int LB = tap_lsbs(k);
    assign tap_pulse[k] = !hold && (&cnt_q[LB-1:0]);
  end

endmodule

// File: rtl/tpre_ext_edge.sv
module tpre_ext_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);

  localparam int SR_W = SYNC_STAGES + 1;

  logic [SR_W-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= {sr_q[SR_W-2:0], pin};
  end

  // sr_q[SYNC_STAGES-1] is the synchronized level, sr_q[SYNC_STAGES] its previous value
  assign rise =  sr_q[SYNC_STAGES-1] && !sr_q[SYNC_STAGES];
  assign fall = !sr_q[SYNC_STAGES-1] &&  sr_q[SYNC_STAGES];

endmodule

// File: rtl/tpre_src_sel.sv
module tpre_src_sel
  import tpre_pkg::*;
(
  input  logic [CSEL_W-1:0]   sel,
  input  logic [NUM_TAPS-1:0] taps,
  input  logic                rise,
  input  logic                fall,
  output logic                en
);

  always_comb en = pick_enable(sel, taps, rise, fall);

endmodule

// File: rtl/tpre_shared_prescaler.sv
module tpre_shared_prescaler
  import tpre_pkg::*;
#(
  parameter int NUM_TIMERS  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [7:0]                   wr_data,
  input  logic [NUM_TIMERS*CSEL_W-1:0] csel,
  input  logic [NUM_TIMERS-1:0]        ext_pin,
  output logic [7:0]                   ctrl_rd,
  output logic [NUM_TIMERS-1:0]        cnt_en
);

  localparam int PSC_W = psc_width();

  logic                  psr_sync_rst;
  logic                  psr_aux_rst;
  logic [NUM_TAPS-1:0]   tap_pulse;
  logic [NUM_TIMERS-1:0] ext_rise;
  logic [NUM_TIMERS-1:0] ext_fall;

  tpre_ctrl_reg u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .ctrl_rd  (ctrl_rd),
    .sync_rst (psr_sync_rst),
    .aux_rst  (psr_aux_rst)
  );

  tpre_psc_core #(.PSC_W(PSC_W)) u_psc (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold      (psr_sync_rst),
    .tap_pulse (tap_pulse)
  );

  for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_timer
    tpre_ext_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .pin   (ext_pin[t]),
      .rise  (ext_rise[t]),
      .fall  (ext_fall[t])
    );

    tpre_src_sel u_sel (
      .sel  (csel[t*CSEL_W +: CSEL_W]),
      .taps (tap_pulse),
      .rise (ext_rise[t]),
      .fall (ext_fall[t]),
      .en   (cnt_en[t])
    );
  end

endmodule

// File: rtl/tpre_checker.sv
module tpre_checker #(
  parameter int NUM_TIMERS = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    wr_en,
  input logic [7:0]              wr_data,
  input logic [NUM_TIMERS*3-1:0] csel,
  input logic [7:0]              ctrl_rd,
  input logic [NUM_TIMERS-1:0]   cnt_en,
  input logic [NUM_TIMERS-1:0]   ext_rise,
  input logic [NUM_TIMERS-1:0]   ext_fall
);

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rd[6:2] == 5'd0); // R1

  AST_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_rd[7] && !wr_en) |=> (ctrl_rd[1:0] == 2'b00)); // R2

  AST_HOLD_IN_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rd[7] && !wr_en) |=> $stable(ctrl_rd)); // R3

  AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[7] && wr_data[1:0] == 2'b00) |=> (ctrl_rd == 8'h00)); // R4

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_chk
    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (csel[i*3 +: 3] == 3'd0) |-> !cnt_en[i]); // R5

    AST_SYSCLK_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
      (csel[i*3 +: 3] == 3'd1) |-> cnt_en[i]); // R6

    AST_TAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_rd[0] && csel[i*3 +: 3] >= 3'd2 && csel[i*3 +: 3] <= 3'd5) |-> !cnt_en[i]); // R8

    AST_EDGE_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_rise[i] || ext_fall[i]) |=> !(ext_rise[i] || ext_fall[i])); // R9
  end

endmodule

bind tpre_shared_prescaler tpre_checker #(.NUM_TIMERS(NUM_TIMERS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .csel     (csel),
  .ctrl_rd  (ctrl_rd),
  .cnt_en   (cnt_en),
  .ext_rise (ext_rise),
  .ext_fall (ext_fall)
);

// File: tb/tpre_shared_prescaler_tb_top.sv
module tpre_shared_prescaler_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NT         = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [7:0]    wr_data = '0;
  logic [NT*3-1:0] csel = '0;
  logic [NT-1:0] ext_pin = '0;
  logic [7:0]    ctrl_rd;
  logic [NT-1:0] cnt_en;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit compare_on = 0;
  logic [NT-1:0] toggle_en = '0;
  int tog_cnt = 0;
  int mismatch_phase = 0;
  int div8_count = 0;

  // behavioural reference state
  bit m_mode, m_srst, m_arst;
  int m_cnt;
  logic [NT-1:0] pin_hist[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tpre_shared_prescaler #(.NUM_TIMERS(NT)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .csel(csel), .ext_pin(ext_pin), .ctrl_rd(ctrl_rd), .cnt_en(cnt_en)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cycles, act, exp);
    end
  endtask

  // reference model update at each rising edge
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_mode = 0; m_srst = 0; m_arst = 0; m_cnt = 0;
      pin_hist = {3'b000, 3'b000, 3'b000};
    end else begin
      m_cnt = m_srst ? 0 : (m_cnt + 1) % 1024;
      if (wr_en) begin
        m_mode = wr_data[7]; m_srst = wr_data[0]; m_arst = wr_data[1];
      end else if (!m_mode) begin
        m_srst = 0; m_arst = 0;
      end
      pin_hist.push_back(ext_pin);
      void'(pin_hist.pop_front());
    end
  end

  function automatic int exp_ctrl();
    return (int'(m_mode) << 7) | (int'(m_arst) << 1) | int'(m_srst);
  endfunction

  function automatic bit exp_en(input int t, output string req);
    int code, div;
    code = int'(csel[t*3 +: 3]);
    // pin_hist[0] = previous synchronized level, pin_hist[1] = synchronized level
    case (code)
      0: begin req = "R5"; return 0; end
      1: begin req = "R6"; return 1; end
      6: begin req = "R9"; return !pin_hist[1][t] && pin_hist[0][t]; end
      7: begin req = "R9"; return pin_hist[1][t] && !pin_hist[0][t]; end
      default: begin
        div = (code == 2) ? 8 : (code == 3) ? 64 : (code == 4) ? 256 : 1024;
        req = m_srst ? "R8" : "R7";
        return !m_srst && (m_cnt % div == div - 1);
      end
    endcase
  endfunction

  // compare a quarter period after each rising edge
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (compare_on) begin
      string r;
      bit e;
      check("R2", int'(ctrl_rd), exp_ctrl());
      for (int t = 0; t < NT; t++) begin
        e = exp_en(t, r);
        check(r, int'(cnt_en[t]), int'(e));
      end
      if (csel[2:0] == 3'd2 && csel[5:3] == 3'd3 && cnt_en[1] && !cnt_en[0])
        mismatch_phase++;
      if (csel[2:0] == 3'd2 && cnt_en[0]) div8_count++;
    end
  end

  // external pin driver: each half period lasts three clocks
  always @(negedge clk) begin
    tog_cnt++;
    if (tog_cnt % 3 == 0) ext_pin <= ext_pin ^ toggle_en;
  end

  task automatic write_ctrl(input logic [7:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_sel(input int t0, input int t1, input int t2);
    @(negedge clk);
    csel = {3'(t2), 3'(t1), 3'(t0)};
  endtask

  // watchdog
  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired at cycle %0d: actual hung expected done", cycles);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    idle(3);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(ctrl_rd), 0);  // reset value
    compare_on = 1;

    // system clock, divide-by-8, rising edges
    set_sel(1, 2, 7);
    toggle_en = 3'b100;
    idle(40);

    // one-shot prescaler reset outside synchronization mode
    write_ctrl(8'h01);
    idle(30);
    check("R2", int'(ctrl_rd), 0);

    // hold everything, reconfigure, release together
    write_ctrl(8'h83);
    set_sel(2, 3, 7);
    toggle_en = 3'b100;  // R10: external edges keep arriving during hold
    idle(25);
    check("R3", int'(ctrl_rd), 8'h83);
    check("R8", int'(cnt_en[1:0]), 0);
    write_ctrl(8'h82);   // write bits while in mode
    idle(5);
    check("R3", int'(ctrl_rd), 8'h82);
    write_ctrl(8'h83);
    idle(5);
    div8_count = 0;
    write_ctrl(8'h00);   // release
    idle(200);
    check("R4", mismatch_phase, 0);
    check("R7", div8_count, 25);

    // slow taps and falling edges
    set_sel(4, 5, 6);
    idle(2200);

    // stopped timer with a toggling pin, system clock during hold
    set_sel(0, 1, 7);
    toggle_en = 3'b111;
    write_ctrl(8'h81);
    idle(40);
    check("R6", int'(cnt_en[1]), 1);
    write_ctrl(8'h01);   // leave mode with a one-cycle reset
    idle(20);

    // reserved bits
    write_ctrl(8'h7C);
    idle(2);
    check("R1", int'(ctrl_rd), 0);

    toggle_en = '0;
    idle(10);
    compare_on = 0;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule